// File: doc/BRIEF.md
# Reset Boot-Configuration Pin Sampler

This block belongs to a reset controller. It drives a reset-out signal for a fixed, parameterised number of clock cycles after any reset request, and near the end of that phase it captures a 2-bit boot-configuration pin bus. The capture happens only when a configuration-enable pin is high. The pins and the enable pin pass through a two-flop synchroniser. The capture point is a fixed four clock edges before reset-out drops.

The latched value is the boot mode handed to the boot program. The same register is the readable reset-status field. A phase started only by a software-initiated external reset leaves the latched mode as it was. A hardware phase with the enable pin low falls back to internal-flash boot. When reset-out negates, a registered one-hot set of boot-source flags is published.

The block has no data stream, so every pin is a plain level or pulse with no handshake. Requests are synchronous one-cycle (or longer) pulses. Power-on reset is asynchronous and active low.

Top module: `boot_cfg_sampler`

## Requirements
- R1: After power-on release or after the last cycle in which a request is high, `rst_out` stays high for exactly `RST_CYCLES` clock cycles and then goes low.
- R2: Any request (`ext_rst_req` or `sw_rst_req`) raises `rst_out` on the next edge, including one that arrives on the edge where `rst_out` would have negated; without a request `rst_out` stays low.
- R3: In a hardware phase, the boot mode is loaded on the edge four edges before `rst_out` negates, from the synchronised pins. A pin change made after that edge has no effect.
- R4: In a hardware phase where the synchronised `cfg_en` is low on the sample edge, the boot mode becomes 2'b00, whatever the pins are.
- R5: A phase started by `sw_rst_req` alone leaves `boot_mode` unchanged, whatever `cfg_en` and the pins are. If `ext_rst_req` is high in the same cycle, or arrives during the phase, the phase is a hardware phase.
- R6: The boot-mode encodings are 2'b00 internal flash, 2'b01 CAN/serial boot, 2'b10 external memory without arbitration and 2'b11 external memory with external arbitration. `boot_flags` is one-hot: bit 0 flash, bit 1 serial, bit 2 external no-arbitration, bit 3 external arbitration. It is registered on the negation edge and matches `boot_mode`.
- R7: `boot_flags` is all zero whenever `rst_out` is high.
- R8: While `rst_out` is low, `boot_mode` does not change, whatever the pins do.
- R9: During power-on reset, `rst_out` is high, `boot_mode` is 2'b00 and `boot_flags` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_req | input | 1 | Hardware (external) reset request, synchronous |
| sw_rst_req | input | 1 | Software-initiated external reset request, synchronous |
| cfg_en | input | 1 | Reset-configuration enable pin, asynchronous |
| cfg_pins | input | 2 | Boot-configuration pins, asynchronous |
| rst_out | output | 1 | Reset-out, high during the reset phase |
| boot_mode | output | 2 | Latched boot mode and reset-status field (R6 encoding) |
| boot_flags | output | 4 | One-hot boot-source flags, valid while `rst_out` is low |

## Verification
Two of the block's functions can fall in the same cycle.

The first pair is the phase restart and the negation. A new request is driven into the very cycle whose edge would drop `rst_out`. The bench judges that `rst_out` stays high, the flags stay zero, and a further full `RST_CYCLES` of reset follows.

The second pair is the software-reset exception and the hardware capture. Both request kinds are pulsed in one cycle with the enable pin high. The bench expects the pins to be captured, as in a hardware phase.

Pin changes are also placed on either side of the sample edge. The bench expects the early change to be captured and the late one to be ignored.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;

  typedef enum logic [1:0] {
    BOOT_FLASH     = 2'b00,
    BOOT_SERIAL    = 2'b01,
    BOOT_EXT_NOARB = 2'b10,
    BOOT_EXT_ARB   = 2'b11
  } boot_mode_e;

  localparam int FLAG_W = 4;

  function automatic logic [FLAG_W-1:0] mode_to_flags(boot_mode_e m);
    logic [FLAG_W-1:0] f;
    f = '0;
    case (m)
      BOOT_FLASH:     f[0] = 1'b1;
      BOOT_SERIAL:    f[1] = 1'b1;
      BOOT_EXT_NOARB: f[2] = 1'b1;
      default:        f[3] = 1'b1;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stage[s] <= '0;
          else        stage[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage[STAGES-1];
endmodule

// File: rtl/rst_phase_seq.sv
module rst_phase_seq #(
  parameter int RST_CYCLES  = 16,
  parameter int SAMPLE_LEAD = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_req,
  input  logic sw_req,
  output logic rst_active,
  output logic hw_phase,
  output logic phase_start,
  output logic sample_stb,
  output logic release_stb
);
  localparam int CW = $clog2(RST_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);
  localparam logic [CW-1:0] STB  = CW'(SAMPLE_LEAD);

  logic [CW-1:0] cnt;
  logic          active;
  logic          kind_hw;

  assign phase_start = ext_req | sw_req;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active  <= 1'b1;
      cnt     <= LOAD;
      kind_hw <= 1'b1;
    end else if (phase_start) begin
      active  <= 1'b1;
      cnt     <= LOAD;
      kind_hw <= ext_req | (active & kind_hw);
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign rst_active  = active;
  assign hw_phase    = kind_hw;
  assign sample_stb  = active & (cnt == STB) & ~phase_start;
  assign release_stb = active & (cnt == '0)  & ~phase_start;
endmodule

// File: rtl/boot_mode_latch.sv
module boot_mode_latch
  import boot_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              phase_start,
  input  logic              sample_stb,
  input  logic              release_stb,
  input  logic              hw_phase,
  input  logic              en_s,
  input  logic [1:0]        pins_s,
  output boot_mode_e        mode,
  output logic [FLAG_W-1:0] flags
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode <= BOOT_FLASH;
    end else if (sample_stb && hw_phase) begin
      mode <= en_s ? boot_mode_e'(pins_s) : BOOT_FLASH;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           flags <= '0;
    else if (phase_start) flags <= '0;
    else if (release_stb) flags <= mode_to_flags(mode);
  end
endmodule

// File: rtl/boot_cfg_sampler.sv
module boot_cfg_sampler
  import boot_cfg_pkg::*;
#(
  parameter int RST_CYCLES  = 16,
  parameter int SAMPLE_LEAD = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_req,
  input  logic              sw_rst_req,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_pins,
  output logic              rst_out,
  output logic [1:0]        boot_mode,
  output logic [FLAG_W-1:0] boot_flags
);
  logic       active, hw_phase, phase_start, sample_stb, release_stb;
  logic [2:0] cfg_s;
  boot_mode_e mode;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .por_n   (por_n),
    .d_async ({cfg_en, cfg_pins}),
    .q_sync  (cfg_s)
  );

  rst_phase_seq #(.RST_CYCLES(RST_CYCLES), .SAMPLE_LEAD(SAMPLE_LEAD)) u_seq (
    .clk         (clk),
    .por_n       (por_n),
    .ext_req     (ext_rst_req),
    .sw_req      (sw_rst_req),
    .rst_active  (active),
    .hw_phase    (hw_phase),
    .phase_start (phase_start),
    .sample_stb  (sample_stb),
    .release_stb (release_stb)
  );

  boot_mode_latch u_latch (
    .clk         (clk),
    .por_n       (por_n),
    .phase_start (phase_start),
    .sample_stb  (sample_stb),
    .release_stb (release_stb),
    .hw_phase    (hw_phase),
    .en_s        (cfg_s[2]),
    .pins_s      (cfg_s[1:0]),
    .mode        (mode),
    .flags       (boot_flags)
  );

  assign rst_out   = active;
  assign boot_mode = mode;
endmodule

// File: rtl/boot_cfg_sampler_chk.sv
module boot_cfg_sampler_chk #(
  parameter int RST_CYCLES = 16
) (
  input logic       clk,
  input logic       por_n,
  input logic       ext_rst_req,
  input logic       sw_rst_req,
  input logic       rst_out,
  input logic [1:0] boot_mode,
  input logic [3:0] boot_flags
);
  localparam int CW = $clog2(RST_CYCLES) + 1;
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic          req;
  logic [CW-1:0] hi_cnt;
  logic          sw_phase;

  assign req = ext_rst_req | sw_rst_req;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       hi_cnt <= '0;
    else if (req)     hi_cnt <= '0;
    else if (rst_out) hi_cnt <= hi_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                       sw_phase <= 1'b0;
    else if (ext_rst_req)             sw_phase <= 1'b0;
    else if (sw_rst_req && !rst_out)  sw_phase <= 1'b1;
  end

  a_r1_release: assert property (@(posedge clk) disable iff (!por_n)
    rst_out && !req && hi_cnt == LAST |=> !rst_out);
  a_r1_hold: assert property (@(posedge clk) disable iff (!por_n)
    rst_out && !req && hi_cnt < LAST |=> rst_out);
  a_r2_restart: assert property (@(posedge clk) disable iff (!por_n)
    req |=> rst_out);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!por_n)
    !rst_out && !req |=> !rst_out);
  a_r5_sw_keep: assert property (@(posedge clk) disable iff (!por_n)
    sw_phase && rst_out |=> $stable(boot_mode));
  a_r6_flags_onehot: assert property (@(posedge clk) disable iff (!por_n)
    !rst_out |-> $countones(boot_flags) == 1);
  a_r6_flags_match: assert property (@(posedge clk) disable iff (!por_n)
    !rst_out |-> boot_flags == (4'b0001 << boot_mode));
  a_r7_flags_clear: assert property (@(posedge clk) disable iff (!por_n)
    rst_out |-> boot_flags == 4'b0000);
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!por_n)
    !rst_out |=> $stable(boot_mode));
endmodule

bind boot_cfg_sampler boot_cfg_sampler_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .ext_rst_req (ext_rst_req),
  .sw_rst_req  (sw_rst_req),
  .rst_out     (rst_out),
  .boot_mode   (boot_mode),
  .boot_flags  (boot_flags)
);

// File: tb/boot_cfg_sampler_tb.sv
module boot_cfg_sampler_tb;
  localparam int RC = 16;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_rst_req = 1'b0;
  logic       sw_rst_req = 1'b0;
  logic       cfg_en = 1'b0;
  logic [1:0] cfg_pins = 2'b00;
  logic       rst_out;
  logic [1:0] boot_mode;
  logic [3:0] boot_flags;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  boot_cfg_sampler #(.RST_CYCLES(RC)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_req(ext_rst_req), .sw_rst_req(sw_rst_req),
    .cfg_en(cfg_en), .cfg_pins(cfg_pins),
    .rst_out(rst_out), .boot_mode(boot_mode), .boot_flags(boot_flags)
  );

  // {sw_only, en, pins[1:0], expected mode[1:0]}
  localparam logic [5:0] VEC [10] = '{
    {1'b0, 1'b1, 2'b01, 2'b01},
    {1'b0, 1'b1, 2'b10, 2'b10},
    {1'b0, 1'b1, 2'b11, 2'b11},
    {1'b0, 1'b1, 2'b00, 2'b00},
    {1'b0, 1'b0, 2'b11, 2'b00},
    {1'b1, 1'b1, 2'b10, 2'b00},
    {1'b0, 1'b1, 2'b10, 2'b10},
    {1'b1, 1'b0, 2'b01, 2'b10},
    {1'b1, 1'b1, 2'b11, 2'b10},
    {1'b0, 1'b0, 2'b01, 2'b00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_low(output int hi);
    hi = 0;
    while (rst_out && hi < 1000) begin
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic run_phase(input bit sw, input bit ext, input bit en,
                           input logic [1:0] pins, output int hi);
    @(negedge clk);
    cfg_en = en; cfg_pins = pins;
    repeat (3) @(negedge clk);
    sw_rst_req = sw; ext_rst_req = ext;
    @(negedge clk);
    sw_rst_req = 1'b0; ext_rst_req = 1'b0;
    wait_low(hi);
  endtask

  task automatic late_change(input int n, input logic [1:0] newp, output int hi);
    @(negedge clk);
    cfg_en = 1'b1; cfg_pins = 2'b01;
    repeat (3) @(negedge clk);
    ext_rst_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ext_rst_req = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cfg_pins = newp;
    wait_low(hi);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi;
    // R9: state during power-on reset
    repeat (3) @(negedge clk);
    chk("R9 rst_out in por", int'(rst_out), 1);
    chk("R9 mode in por", int'(boot_mode), 0);
    chk("R9 flags in por", int'(boot_flags), 0);
    por_n = 1'b1;
    wait_low(hi);
    chk("R1 por phase length", hi, RC);
    chk("R4 por phase with en low", int'(boot_mode), 0);
    chk("R6 flags after por", int'(boot_flags), 1);

    for (int i = 0; i < 10; i++) begin
      logic [5:0] v;
      v = VEC[i];
      run_phase(v[5], ~v[5], v[4], v[3:2], hi);
      chk($sformatf("R1 length vec %0d", i), hi, RC);
      chk($sformatf("R3/R4/R5 mode vec %0d", i), int'(boot_mode), int'(v[1:0]));
      chk($sformatf("R6 flags vec %0d", i), int'(boot_flags), 1 << v[1:0]);
    end

    // R5: both request kinds in one cycle make a hardware phase
    run_phase(1'b1, 1'b1, 1'b1, 2'b11, hi);
    chk("R5 sw+ext same cycle captures", int'(boot_mode), 3);

    // R3: pin change before the sample edge is captured
    late_change(RC - 7, 2'b10, hi);
    chk("R3 early change captured", int'(boot_mode), 2);
    // R3: pin change after the sample edge is ignored
    late_change(RC - 4, 2'b10, hi);
    chk("R3 late change ignored", int'(boot_mode), 1);

    // R2: request on the negation edge restarts the phase
    @(negedge clk);
    cfg_en = 1'b1; cfg_pins = 2'b10;
    repeat (3) @(negedge clk);
    ext_rst_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ext_rst_req = 1'b0;
    repeat (RC - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 still high before last edge", int'(rst_out), 1);
    ext_rst_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ext_rst_req = 1'b0;
    chk("R2 restart keeps rst_out high", int'(rst_out), 1);
    chk("R7 flags zero on restart", int'(boot_flags), 0);
    wait_low(hi);
    chk("R2 full length after restart", hi, RC);
    chk("R6 mode after restart", int'(boot_mode), 2);

    // R8: pins and enable toggle while idle
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_pins = 2'(k);
      cfg_en = k[0];
    end
    repeat (4) @(negedge clk);
    chk("R8 mode held while idle", int'(boot_mode), 2);
    chk("R2 rst_out stays low", int'(rst_out), 0);
    chk("R6 flags held while idle", int'(boot_flags), 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule